// File: doc/BRIEF.md
# Asynchronous Parallel Register Bus Master

This block lets synchronous logic talk to a peripheral that exposes its registers over a byte-wide asynchronous port. That port has a 6-bit address, an 8-bit data path, and separate active-low read and write strobes. The master accepts one read or one write at a time on a valid/ready command interface. It places the address and any write data on the port, and it moves the strobes only on system-clock edges. It returns a one-cycle response, which carries the captured byte when the command was a read.

Every timing limit of the port is a parameter given in picoseconds. At elaboration the block turns each limit into a whole number of clock cycles using ceiling division against the clock-period parameter. Each strobe phase has its own counter sized for its own limit: write setup, write low time, write data hold, write recovery, read access and read recovery. The master drives the data lines only during writes, through an output enable. It keeps the command interface busy until the recovery after the strobe has ended, so a command issued straight after a response always meets the port's turnaround limits.

Top module: `pbus_master`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of a transfer, returns the block to idle. In idle both strobes are high, the output enable is low, cmd_ready is high and rsp_valid is low.
- R2: A write is accepted on a clock edge where cmd_valid, cmd_ready and cmd_write are all high. On that edge the address and data are driven with the output enable high. The write strobe falls exactly WSU cycles later, where WSU = max(1, ceil(addr setup/period), ceil(data setup/period)).
- R3: The write strobe stays low for exactly WLO = max(1, ceil(low time/period)) cycles. While it is low, the address and data do not change and the read strobe stays high.
- R4: The output enable, and with it the data, stays high for exactly WDH = max(1, ceil(data hold/period)) cycles after the write strobe rises. The response comes WREC = max(1, WDH, ceil(high time/period)) cycles after the rise.
- R5: A read is accepted on an edge where cmd_valid and cmd_ready are high and cmd_write is low. On that edge the address is applied and the read strobe falls together. The output enable is low for the whole read.
- R6: The read strobe stays low for exactly RACC = max(1, ceil(addr access/period), ceil(strobe access/period)) cycles. The input data is sampled on the edge that raises the strobe, and that value is returned on rsp_rdata.
- R7: After the read strobe rises, the address is held and the data lines stay undriven for RREC = max(1, ceil(addr hold/period), ceil(release time/period)) cycles before the response.
- R8: cmd_ready is low from the accepting edge until the response. A cmd_valid raised while cmd_ready is low is ignored, and it changes neither the bus nor the target.
- R9: rsp_valid is a single-cycle pulse, and it appears in the same cycle that cmd_ready returns high. rsp_rdata changes only when a read samples data, so a write leaves it unchanged.
- R10: A command presented in the response cycle is accepted on the next edge with no idle cycle. Between two writes the write strobe is then high for WREC + 1 + WSU cycles, which is at least the high-time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Master idle and able to accept a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W (6) | Register address |
| cmd_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (8) | Data from the last read |
| bus_addr | output | ADDR_W (6) | Port address lines |
| bus_dout | output | DATA_W (8) | Port data, driven side |
| bus_oe | output | 1 | Enable for bus_dout onto the shared data lines |
| bus_din | input | DATA_W (8) | Port data, received side |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench keeps the default picosecond limits and declares a 5 ns clock period, even though its stimulus clock runs at 50 MHz. Only the cycle counts matter to the sequencing, and this period gives distinct counts: write setup 2, low 2, data hold 1, recovery 3, read access 3 and read recovery 2. With those counts an off-by-one in any single phase, a swapped phase, or early sampling of read data shows up on its own. The target model returns wrong data until the read strobe has been low for the full access count.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int PH_N    = 6;
  localparam int PH_WSU  = 0;
  localparam int PH_WLO  = 1;
  localparam int PH_WDH  = 2;
  localparam int PH_WREC = 3;
  localparam int PH_RACC = 4;
  localparam int PH_RREC = 5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSU  = 3'd1,
    ST_WLO  = 3'd2,
    ST_WREC = 3'd3,
    ST_RACC = 3'd4,
    ST_RREC = 3'd5
  } pbus_state_e;

  typedef struct packed {
    logic acc_wr;
    logic acc_rd;
    logic wr_fall;
    logic wr_rise;
    logic oe_off;
    logic rd_rise;
    logic done;
  } pbus_evt_t;

  // ceiling of a picosecond limit over the clock period; zero stays zero
  function automatic int unsigned cyc_of(input int unsigned ps, input int unsigned clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
  parameter int unsigned CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int unsigned CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic            cmd_write,
  input  logic [PH_N-1:0] ph_done,
  output logic [PH_N-1:0] ph_run,
  output pbus_evt_t       evt
);
  pbus_state_e state, state_nx;

  always_comb begin
    ph_run          = '0;
    ph_run[PH_WSU]  = (state == ST_WSU);
    ph_run[PH_WLO]  = (state == ST_WLO);
    ph_run[PH_WDH]  = (state == ST_WREC);
    ph_run[PH_WREC] = (state == ST_WREC);
    ph_run[PH_RACC] = (state == ST_RACC);
    ph_run[PH_RREC] = (state == ST_RREC);
  end

  always_comb begin
    evt.acc_wr  = (state == ST_IDLE) && cmd_valid && cmd_write;
    evt.acc_rd  = (state == ST_IDLE) && cmd_valid && !cmd_write;
    evt.wr_fall = (state == ST_WSU)  && ph_done[PH_WSU];
    evt.wr_rise = (state == ST_WLO)  && ph_done[PH_WLO];
    evt.oe_off  = ph_done[PH_WDH];
    evt.rd_rise = (state == ST_RACC) && ph_done[PH_RACC];
    evt.done    = ((state == ST_WREC) && ph_done[PH_WREC]) ||
                  ((state == ST_RREC) && ph_done[PH_RREC]);
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (evt.acc_wr) state_nx = ST_WSU;
               else if (evt.acc_rd) state_nx = ST_RACC;
      ST_WSU:  if (evt.wr_fall) state_nx = ST_WLO;
      ST_WLO:  if (evt.wr_rise) state_nx = ST_WREC;
      ST_WREC: if (evt.done)    state_nx = ST_IDLE;
      ST_RACC: if (evt.rd_rise) state_nx = ST_RREC;
      ST_RREC: if (evt.done)    state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/pbus_io_regs.sv
module pbus_io_regs
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pbus_evt_t         evt,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      bus_addr  <= '0;
      bus_dout  <= '0;
      bus_oe    <= 1'b0;
      bus_rd_n  <= 1'b1;
      bus_wr_n  <= 1'b1;
    end else begin
      rsp_valid <= 1'b0;
      if (evt.acc_wr || evt.acc_rd) begin
        cmd_ready <= 1'b0;
        bus_addr  <= cmd_addr;
      end
      if (evt.acc_wr) begin
        bus_dout <= cmd_wdata;
        bus_oe   <= 1'b1;
      end
      if (evt.acc_rd)  bus_rd_n <= 1'b0;
      if (evt.wr_fall) bus_wr_n <= 1'b0;
      if (evt.wr_rise) bus_wr_n <= 1'b1;
      if (evt.oe_off)  bus_oe   <= 1'b0;
      if (evt.rd_rise) begin
        rsp_rdata <= bus_din;
        bus_rd_n  <= 1'b1;
      end
      if (evt.done) begin
        cmd_ready <= 1'b1;
        rsp_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int          ADDR_W          = 6,
  parameter int          DATA_W          = 8,
  parameter int unsigned CLK_PS          = 10000,
  parameter int unsigned T_WR_ASU_PS     = 8000,
  parameter int unsigned T_WR_DSU_PS     = 3000,
  parameter int unsigned T_WR_DHD_PS     = 2500,
  parameter int unsigned T_WR_LOW_PS     = 7000,
  parameter int unsigned T_WR_HIGH_PS    = 10500,
  parameter int unsigned T_RD_AACC_PS    = 15000,
  parameter int unsigned T_RD_SACC_PS    = 15000,
  parameter int unsigned T_RD_AHD_PS     = 5000,
  parameter int unsigned T_RD_RELEASE_PS = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  localparam int unsigned WSU_C  = max_u(1, max_u(cyc_of(T_WR_ASU_PS, CLK_PS),
                                                  cyc_of(T_WR_DSU_PS, CLK_PS)));
  localparam int unsigned WLO_C  = max_u(1, cyc_of(T_WR_LOW_PS, CLK_PS));
  localparam int unsigned WDH_C  = max_u(1, cyc_of(T_WR_DHD_PS, CLK_PS));
  localparam int unsigned WREC_C = max_u(WDH_C, cyc_of(T_WR_HIGH_PS, CLK_PS));
  localparam int unsigned RACC_C = max_u(1, max_u(cyc_of(T_RD_AACC_PS, CLK_PS),
                                                  cyc_of(T_RD_SACC_PS, CLK_PS)));
  localparam int unsigned RREC_C = max_u(1, max_u(cyc_of(T_RD_AHD_PS, CLK_PS),
                                                  cyc_of(T_RD_RELEASE_PS, CLK_PS)));
  localparam int unsigned PH_CYC [PH_N] = '{WSU_C, WLO_C, WDH_C, WREC_C, RACC_C, RREC_C};

  logic [PH_N-1:0] ph_run;
  logic [PH_N-1:0] ph_done;
  pbus_evt_t       evt;

  for (genvar g = 0; g < PH_N; g++) begin : g_phase
    pbus_phase_timer #(.CYCLES(PH_CYC[g])) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .run  (ph_run[g]),
      .done (ph_done[g])
    );
  end

  pbus_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .ph_done   (ph_done),
    .ph_run    (ph_run),
    .evt       (evt)
  );

  pbus_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .bus_din   (bus_din),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n)
  );
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_oe,
  input logic              bus_rd_n,
  input logic              bus_wr_n
);
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    rst |=> (bus_rd_n && bus_wr_n && !bus_oe && cmd_ready && !rsp_valid));

  assert_wr_fall_with_data_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wr_n) |-> bus_oe);

  assert_wr_low_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_addr) && $stable(bus_dout)));

  assert_data_held_at_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> bus_oe);

  assert_no_drive_in_read_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> (!bus_oe && bus_wr_n));

  assert_rd_starts_on_accept_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd_n) |-> $past(cmd_valid && cmd_ready && !cmd_write));

  assert_busy_while_strobing_R8: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n || !bus_rd_n || bus_oe) |-> !cmd_ready);

  assert_rsp_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_rsp_with_ready_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cmd_ready);

  assert_rdata_only_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> $rose(bus_rd_n));
endmodule

bind pbus_master pbus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_write (cmd_write),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .bus_addr  (bus_addr),
  .bus_dout  (bus_dout),
  .bus_oe    (bus_oe),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n)
);

// File: tb/tb_pbus_master.sv
module tb_pbus_master;
  localparam int          AW     = 6;
  localparam int          DW     = 8;
  localparam int unsigned CLK_PS = 5000;

  function automatic int cyc(input int ps);
    int c;
    c = (ps + int'(CLK_PS) - 1) / int'(CLK_PS);
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WSU  = 2;
  localparam int WLO  = 2;
  localparam int WDH  = 1;
  localparam int WREC = 3;
  localparam int RACC = 3;
  localparam int RREC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, bus_oe, bus_rd_n, bus_wr_n;
  logic [DW-1:0] rsp_rdata, bus_dout, bus_din;
  logic [AW-1:0] bus_addr;

  always #10 clk = ~clk;

  pbus_master #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target register file and golden copy
  logic [DW-1:0] mem_t [64];
  logic [DW-1:0] ref_m [64];
  int rd_lo = 0;
  logic t_prev_wr = 1'b1;
  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_t[i] = DW'(i * 7 + 3);
      ref_m[i] = DW'(i * 7 + 3);
    end
    bus_din = '0;
  end

  always @(negedge clk) begin
    if (!bus_rd_n) rd_lo++; else rd_lo = 0;
    bus_din = (rd_lo >= RACC) ? mem_t[bus_addr] : ~mem_t[bus_addr];
    if (!t_prev_wr && bus_wr_n && bus_oe) mem_t[bus_addr] = bus_dout;
    t_prev_wr = bus_wr_n;
  end

  // phase monitor
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic [DW-1:0] last_rd = '0;
  int  busy = 0, hi_cnt = 1000;
  bit  is_wr = 0;
  logic p_wr = 1'b1, p_rd = 1'b1, p_oe = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      busy = 0;
    end else if (!cmd_ready) begin
      busy++;
      if (busy == 1) begin
        is_wr = bus_oe;
        if (!is_wr) chk(!bus_rd_n, "R5 rd low on accept", bus_rd_n, 0);
      end
      if (is_wr) begin
        chk(bus_addr == exp_addr, "R3 write addr", bus_addr, exp_addr);
        chk(bus_rd_n, "R3 rd idle in write", bus_rd_n, 1);
        if (p_wr && !bus_wr_n) begin
          chk(busy == WSU + 1, "R2 setup cycles", busy - 1, WSU);
          chk(hi_cnt >= WREC + 1 + WSU, "R10 strobe high gap", hi_cnt, WREC + 1 + WSU);
          chk(hi_cnt >= cyc(10500), "R10 high time", hi_cnt, cyc(10500));
        end
        if (!p_wr && bus_wr_n) chk(busy == WSU + WLO + 1, "R3 low cycles", busy - 1 - WSU, WLO);
        if (p_oe && !bus_oe)  chk(busy == WSU + WLO + WDH + 1, "R4 data hold", busy - 1 - WSU - WLO, WDH);
        if (!bus_wr_n) chk(bus_dout == exp_data && bus_oe, "R3 write data", bus_dout, exp_data);
      end else begin
        chk(!bus_oe, "R5 no drive in read", bus_oe, 0);
        chk(bus_addr == exp_addr, "R7 read addr held", bus_addr, exp_addr);
        if (!p_rd && bus_rd_n) chk(busy == RACC + 1, "R6 access cycles", busy - 1, RACC);
      end
    end else if (busy != 0) begin
      chk(rsp_valid, "R9 rsp with ready", rsp_valid, 1);
      if (is_wr) chk(busy == WSU + WLO + WREC, "R4 write busy", busy, WSU + WLO + WREC);
      else       chk(busy == RACC + RREC, "R7 read busy", busy, RACC + RREC);
      busy = 0;
    end else begin
      chk(!rsp_valid, "R9 no stray rsp", rsp_valid, 0);
    end
    if (bus_wr_n) hi_cnt++; else hi_cnt = 0;
    p_wr = bus_wr_n; p_rd = bus_rd_n; p_oe = bus_oe;
  end

  // driver: called at a negedge
  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, output int waits);
    waits = 0;
    while (!cmd_ready) begin @(negedge clk); waits++; end
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    exp_addr = a; exp_data = d;
    if (w) ref_m[a] = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_cmd(input bit w, input logic [AW-1:0] a);
    while (!rsp_valid) @(negedge clk);
    if (w) chk(rsp_rdata == last_rd, "R9 rdata kept on write", rsp_rdata, last_rd);
    else begin
      chk(rsp_rdata == ref_m[a], "R6 read data", rsp_rdata, ref_m[a]);
      last_rd = rsp_rdata;
    end
  endtask

  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int wt;
    issue(w, a, d, wt);
    finish_cmd(w, a);
  endtask

  bit finished = 0;
  initial begin
    int wt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready && bus_rd_n && bus_wr_n && !bus_oe && !rsp_valid, "R1 reset idle", {cmd_ready, bus_rd_n, bus_wr_n, bus_oe, rsp_valid}, 5'b11100);

    // directed: write then read back, back-to-back
    xfer(1, 6'd12, 8'hA5);
    issue(0, 6'd12, 8'h00, wt);
    chk(wt == 0, "R10 accept right after rsp", wt, 0);
    finish_cmd(0, 6'd12);
    issue(1, 6'd63, 8'hFF, wt); finish_cmd(1, 6'd63);
    issue(1, 6'd0, 8'h00, wt);
    chk(wt == 0, "R10 write after write", wt, 0);
    finish_cmd(1, 6'd0);
    xfer(0, 6'd63, 8'h00);
    xfer(0, 6'd0, 8'h00);

    // command raised while busy must be ignored
    issue(1, 6'd10, 8'h3C, wt);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 6'd5; cmd_wdata = 8'hEE;
    @(negedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    finish_cmd(1, 6'd10);
    xfer(0, 6'd5, 8'h00);
    chk(rsp_rdata == ref_m[5], "R8 ignored command left target", rsp_rdata, ref_m[5]);
    xfer(0, 6'd10, 8'h00);

    // reset during a read
    issue(0, 6'd7, 8'h00, wt);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(cmd_ready && bus_rd_n && bus_wr_n && !bus_oe && !rsp_valid, "R1 reset mid read", {cmd_ready, bus_rd_n, bus_wr_n, bus_oe, rsp_valid}, 5'b11100);
    last_rd = rsp_rdata;

    // random traffic
    for (int k = 0; k < 300; k++) begin
      bit w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int gap;
      w = $urandom_range(0, 1) == 1;
      a = AW'($urandom_range(0, 63));
      d = DW'($urandom_range(0, 255));
      gap = $urandom_range(0, 3);
      repeat (gap) @(negedge clk);
      xfer(w, a, d);
    end

    // final sweep of the target contents
    for (int i = 0; i < 64; i += 9) xfer(0, AW'(i), 8'h00);
    for (int i = 0; i < 64; i++) chk(mem_t[i] == ref_m[i], "R3 target contents", mem_t[i], ref_m[i]);

    chk(mx(cyc(8000), cyc(3000)) == WSU && cyc(7000) == WLO && mx(cyc(15000), cyc(15000)) == RACC,
        "R2 count derivation", WSU, mx(cyc(8000), cyc(3000)));
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule